// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block holds a seconds count and a sub-second count that together form the local time base used to stamp network packets. Software sets it up through a small word-wide register port. It loads an absolute time, sets the per-tick increment, chooses how the sub-second field wraps, and steers the rate. Software reads the live seconds and sub-second values back through the same port.

Two rate modes exist. In coarse mode the increment is added on every clock. In fine mode a 32-bit phase accumulator adds a working addend on every clock, and the increment is added only on the clocks where that accumulator carries out. Software trims the frequency by changing the addend. Three one-shot commands are issued through the control register and clear themselves once applied: load an absolute time, add or subtract an offset, and copy a new addend into the working copy.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset every register reads zero, including the control word, the live seconds and the live sub-second value.
- R2: With the enable bit (control bit 0) set and the fine bit (control bit 1) clear, the sub-second value grows by the increment field (bits 15:8 of the increment register, address 1) on every clock.
- R3: With enable and the fine bit set, a 32-bit accumulator adds the working addend on every clock, and the increment is added only on clocks where that sum carries out. A working addend of 2^31 gives exactly one step every two clocks.
- R4: When the sub-second value plus the step reaches or passes the rollover value, the rollover value is subtracted and seconds rise by one, modulo 2^32. The rollover value is 10^9 when control bit 2 is set, and 2^31 when that bit is clear.
- R5: Writing control bit 3 (load time) loads the seconds preset (address 3) and bits 30:0 of the sub-second preset (address 4) into the time, one clock after the write. No increment is added on that clock. The bit reads 1 in between and 0 afterwards.
- R6: Writing control bit 4 (step time) with bit 31 of the sub-second preset clear adds both presets to the time one clock later. When the sub-second sum reaches the rollover value, the rollover value is removed and a carry goes into seconds.
- R7: With bit 31 of the sub-second preset set, a step subtracts. Software writes 2^32 minus the seconds amount and the rollover value minus the sub-second amount, where the sub-second amount is nonzero. When the sub-second sum stays below the rollover value, seconds take a borrow of one.
- R8: Writing control bit 5 (load addend) copies the addend register (address 2) into the working addend one clock later. The old working addend is still used on that clock, and the bit then clears.
- R9: When several command bits are written together, only the highest-priority one is applied and all of them clear. Load time beats step time, and step time beats load addend.
- R10: While the enable bit is clear the time and the accumulator hold their values, and command bits written with enable clear are dropped and read back as zero.
- R11: The read port returns each register combinationally. Live seconds are at address 5, the live sub-second value at address 6, and presets and settings read back at their own addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data for rd_addr |

## Verification
On every cycle, assertions check the following:
- Command bits clear one clock after they are set, and at most one command fires at a time.
- No command is stored while the block is disabled, and time holds while it is disabled.
- Free-running counting moves seconds by at most one per clock.
- A load places the presets exactly into the time.
- A working addend of one half never carries on two clocks in a row.

Only the bench scenarios can show the arithmetic results against the expected values: decimal and binary wrap points, seconds wrap at 2^32, add and subtract steps with carry and borrow, the rate obtained for a given addend, and which command wins when several are written together.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL    = 3'd0,
      RA_INCR    = 3'd1,
      RA_ADDEND  = 3'd2,
      RA_SEC_SET = 3'd3,
      RA_SUB_SET = 3'd4,
      RA_SEC_NOW = 3'd5,
      RA_SUB_NOW = 3'd6,
      RA_SPARE   = 3'd7
   } reg_addr_e;

   // control word bit positions
   localparam int CB_EN   = 0;
   localparam int CB_FINE = 1;
   localparam int CB_DEC  = 2;
   localparam int CB_INIT = 3;
   localparam int CB_STEP = 4;
   localparam int CB_LOAD = 5;
   localparam int CTRL_W  = 6;

   // packed so that 'en' lands on bit 0, matching CB_* above
   typedef struct packed {
      logic load;
      logic step;
      logic init;
      logic dec;
      logic fine;
      logic en;
   } ctrl_t;

   typedef struct packed {
      logic init;
      logic step;
      logic load;
   } cmd_t;

   localparam longint DEC_ROLL = 64'd1000000000;

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
   import ptp_tc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SEC_W     = 32,
   parameter int SUB_W     = 31,
   parameter int ACC_W     = 32,
   parameter int INC_W     = 8,
   parameter int INC_SHIFT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   input  logic [SEC_W-1:0]  sec_now,
   input  logic [SUB_W-1:0]  sub_now,
   output logic [DATA_W-1:0] rd_data,
   output ctrl_t             ctrl_o,
   output cmd_t              go_o,
   output logic [INC_W-1:0]  incr_o,
   output logic [ACC_W-1:0]  addend_o,
   output logic [SEC_W-1:0]  sec_set_o,
   output logic [SUB_W-1:0]  sub_set_o,
   output logic              sub_neg_o
);

   reg_addr_e wa;
   reg_addr_e ra;
   logic      ctrl_wr;

   assign wa      = reg_addr_e'(wr_addr);
   assign ra      = reg_addr_e'(rd_addr);
   assign ctrl_wr = wr_en && (wa == RA_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o    <= '0;
         incr_o    <= '0;
         addend_o  <= '0;
         sec_set_o <= '0;
         sub_set_o <= '0;
         sub_neg_o <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            ctrl_o.en   <= wr_data[CB_EN];
            ctrl_o.fine <= wr_data[CB_FINE];
            ctrl_o.dec  <= wr_data[CB_DEC];
            ctrl_o.init <= wr_data[CB_INIT] & wr_data[CB_EN];
            ctrl_o.step <= wr_data[CB_STEP] & wr_data[CB_EN];
            ctrl_o.load <= wr_data[CB_LOAD] & wr_data[CB_EN];
         end else begin
            ctrl_o.init <= 1'b0;
            ctrl_o.step <= 1'b0;
            ctrl_o.load <= 1'b0;
         end
         if (wr_en && wa == RA_INCR)    incr_o    <= wr_data[INC_SHIFT +: INC_W];
         if (wr_en && wa == RA_ADDEND)  addend_o  <= wr_data[ACC_W-1:0];
         if (wr_en && wa == RA_SEC_SET) sec_set_o <= wr_data[SEC_W-1:0];
         if (wr_en && wa == RA_SUB_SET) begin
            sub_set_o <= wr_data[SUB_W-1:0];
            sub_neg_o <= wr_data[DATA_W-1];
         end
      end
   end

   // fixed priority: load time, then step time, then load addend
   always_comb begin
      go_o.init = ctrl_o.en & ctrl_o.init;
      go_o.step = ctrl_o.en & ctrl_o.step & ~ctrl_o.init;
      go_o.load = ctrl_o.en & ctrl_o.load & ~ctrl_o.init & ~ctrl_o.step;
   end

   always_comb begin
      rd_data = '0;
      case (ra)
         RA_CTRL:    rd_data[CTRL_W-1:0]         = ctrl_o;
         RA_INCR:    rd_data[INC_SHIFT +: INC_W] = incr_o;
         RA_ADDEND:  rd_data[ACC_W-1:0]          = addend_o;
         RA_SEC_SET: rd_data[SEC_W-1:0]          = sec_set_o;
         RA_SUB_SET: begin
            rd_data[SUB_W-1:0]  = sub_set_o;
            rd_data[DATA_W-1]   = sub_neg_o;
         end
         RA_SEC_NOW: rd_data[SEC_W-1:0]          = sec_now;
         RA_SUB_NOW: rd_data[SUB_W-1:0]          = sub_now;
         default:    rd_data = '0;
      endcase
   end

   assert_init_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o.init && !ctrl_wr) |=> !ctrl_o.init);

   assert_step_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o.step && !ctrl_wr) |=> !ctrl_o.step);

   assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o.load && !ctrl_wr) |=> !ctrl_o.load);

   assert_single_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(go_o));

   assert_off_no_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_o.en |-> !(ctrl_o.init || ctrl_o.step || ctrl_o.load));

endmodule

// File: rtl/ptp_tc_rate.sv
module ptp_tc_rate #(
   parameter int ACC_W   = 32,
   parameter bit FINE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             fine,
   input  logic             load,
   input  logic [ACC_W-1:0] addend_set,
   output logic             tick
);

   localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

   generate
      if (FINE_EN) begin : g_fine
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] addend_work;
         logic [ACC_W-1:0] acc_nxt;
         logic             carry;

         assign {carry, acc_nxt} = {1'b0, acc_q} + {1'b0, addend_work};
         assign tick = en & (~fine | carry);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q       <= '0;
               addend_work <= '0;
            end else begin
               if (load)        addend_work <= addend_set;
               if (en && fine)  acc_q       <= acc_nxt;
            end
         end

         assert_half_addend_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (en && fine && addend_work == HALF && tick) |=>
            (!(en && fine && addend_work == HALF) || !tick));
      end else begin : g_coarse
         logic unused_rate;
         assign unused_rate = ^{fine, load, addend_set, clk, rst_n, HALF};
         assign tick = en;
      end
   endgenerate

endmodule

// File: rtl/ptp_tc_time.sv
module ptp_tc_time
   import ptp_tc_pkg::*;
#(
   parameter int SEC_W = 32,
   parameter int SUB_W = 31,
   parameter int INC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             dec,
   input  cmd_t             go,
   input  logic             tick,
   input  logic [INC_W-1:0] incr,
   input  logic [SEC_W-1:0] sec_set,
   input  logic [SUB_W-1:0] sub_set,
   input  logic             sub_neg,
   output logic [SEC_W-1:0] sec_q,
   output logic [SUB_W-1:0] sub_q
);

   localparam int SW1 = SUB_W + 1;
   localparam logic [SW1-1:0] ROLL_DEC = SW1'(DEC_ROLL);
   localparam logic [SW1-1:0] ROLL_BIN = SW1'(1) << SUB_W;

   logic [SW1-1:0]   roll;
   logic [SW1-1:0]   inc_sum, inc_res;
   logic [SW1-1:0]   adj_sum, adj_res;
   logic             inc_wrap, adj_over;
   logic [SEC_W-1:0] adj_sec;

   always_comb begin
      roll     = dec ? ROLL_DEC : ROLL_BIN;
      inc_sum  = {1'b0, sub_q} + SW1'(incr);
      inc_wrap = (inc_sum >= roll);
      inc_res  = inc_wrap ? (inc_sum - roll) : inc_sum;
      adj_sum  = {1'b0, sub_q} + {1'b0, sub_set};
      adj_over = (adj_sum >= roll);
      adj_res  = adj_over ? (adj_sum - roll) : adj_sum;
      // add: carry in on overflow; subtract: borrow when no overflow
      adj_sec  = sec_q + sec_set + SEC_W'(adj_over) - SEC_W'(sub_neg);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '0;
         sub_q <= '0;
      end else if (go.init) begin
         sec_q <= sec_set;
         sub_q <= sub_set;
      end else if (go.step) begin
         sec_q <= adj_sec;
         sub_q <= adj_res[SUB_W-1:0];
      end else if (tick) begin
         sec_q <= sec_q + SEC_W'(inc_wrap);
         sub_q <= inc_res[SUB_W-1:0];
      end
   end

   assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(sec_q) && $stable(sub_q)));

   assert_sec_moves_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !go.init && !go.step) |=>
      ((sec_q == $past(sec_q)) || (sec_q == $past(sec_q) + 1'b1)));

   assert_load_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
      go.init |=> ((sec_q == $past(sec_set)) && (sub_q == $past(sub_set))));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
   import ptp_tc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SEC_W     = 32,
   parameter int SUB_W     = 31,
   parameter int ACC_W     = 32,
   parameter int INC_W     = 8,
   parameter int INC_SHIFT = 8,
   parameter bit FINE_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (SUB_W < 30 || SUB_W >= DATA_W) begin : g_chk_sub
         $error("sub-second width must hold 10^9 and leave the top data bit for the sign flag");
      end
      if (SEC_W > DATA_W || ACC_W > DATA_W) begin : g_chk_wide
         $error("seconds and accumulator must fit in one data word");
      end
      if (INC_SHIFT + INC_W > DATA_W || INC_W >= SUB_W) begin : g_chk_inc
         $error("increment field must fit in the data word and below the sub-second width");
      end
      if (CTRL_W > DATA_W) begin : g_chk_ctrl
         $error("control word does not fit in the data word");
      end
   endgenerate

   ctrl_t            ctrl;
   cmd_t             go;
   logic [INC_W-1:0] incr;
   logic [ACC_W-1:0] addend_set;
   logic [SEC_W-1:0] sec_set, sec_now;
   logic [SUB_W-1:0] sub_set, sub_now;
   logic             sub_neg;
   logic             tick;

   ptp_tc_regs #(
      .DATA_W(DATA_W), .SEC_W(SEC_W), .SUB_W(SUB_W),
      .ACC_W(ACC_W), .INC_W(INC_W), .INC_SHIFT(INC_SHIFT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .sec_now   (sec_now),
      .sub_now   (sub_now),
      .rd_data   (rd_data),
      .ctrl_o    (ctrl),
      .go_o      (go),
      .incr_o    (incr),
      .addend_o  (addend_set),
      .sec_set_o (sec_set),
      .sub_set_o (sub_set),
      .sub_neg_o (sub_neg)
   );

   ptp_tc_rate #(.ACC_W(ACC_W), .FINE_EN(FINE_EN)) u_rate (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl.en),
      .fine       (ctrl.fine),
      .load       (go.load),
      .addend_set (addend_set),
      .tick       (tick)
   );

   ptp_tc_time #(.SEC_W(SEC_W), .SUB_W(SUB_W), .INC_W(INC_W)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl.en),
      .dec     (ctrl.dec),
      .go      (go),
      .tick    (tick),
      .incr    (incr),
      .sec_set (sec_set),
      .sub_set (sub_set),
      .sub_neg (sub_neg),
      .sec_q   (sec_now),
      .sub_q   (sub_now)
   );

endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = 3'd5;
   logic [31:0] rd_data;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ptp_time_counter u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // ---------------- behavioural reference model ----------------
   longint m_sec, m_sub, m_acc, m_addw, m_addend, m_secu, m_subu, m_inc;
   bit     m_en, m_fine, m_dec, m_init, m_step, m_load, m_neg;

   always @(posedge clk) begin
      longint roll, s, asum;
      bit     tk, c;
      if (!rst_n) begin
         m_sec = 0; m_sub = 0; m_acc = 0; m_addw = 0; m_addend = 0;
         m_secu = 0; m_subu = 0; m_inc = 0;
         m_en = 0; m_fine = 0; m_dec = 0; m_init = 0; m_step = 0; m_load = 0; m_neg = 0;
      end else begin
         roll = m_dec ? 64'd1000000000 : 64'h8000_0000;
         tk = 1'b0;
         if (m_en) begin
            if (m_fine) begin
               asum  = m_acc + m_addw;
               tk    = (asum >= 64'h1_0000_0000);
               m_acc = asum & 64'hFFFF_FFFF;
            end else tk = 1'b1;
         end
         if (m_en && m_init) begin
            m_sec = m_secu; m_sub = m_subu;
         end else if (m_en && m_step) begin
            s = m_sub + m_subu;
            c = (s >= roll);
            if (c) s = s - roll;
            m_sub = s;
            m_sec = (m_sec + m_secu + (c ? 1 : 0) - (m_neg ? 1 : 0)) & 64'hFFFF_FFFF;
         end else if (tk) begin
            s = m_sub + m_inc;
            if (s >= roll) begin
               s = s - roll;
               m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
            end
            m_sub = s;
         end
         if (m_en && m_load && !m_init && !m_step) m_addw = m_addend;
         if (wr_en && wr_addr == 3'd0) begin
            m_en = wr_data[0]; m_fine = wr_data[1]; m_dec = wr_data[2];
            m_init = wr_data[3] & wr_data[0];
            m_step = wr_data[4] & wr_data[0];
            m_load = wr_data[5] & wr_data[0];
         end else begin
            m_init = 0; m_step = 0; m_load = 0;
         end
         if (wr_en && wr_addr == 3'd1) m_inc = longint'(wr_data[15:8]);
         if (wr_en && wr_addr == 3'd2) m_addend = longint'(wr_data);
         if (wr_en && wr_addr == 3'd3) m_secu = longint'(wr_data);
         if (wr_en && wr_addr == 3'd4) begin
            m_subu = longint'(wr_data[30:0]);
            m_neg  = wr_data[31];
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", tag, act, act, exp, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rd_addr == 3'd5)
            chk(m_fine ? "R3 live seconds" : "R2 live seconds", rd_data, 32'(m_sec));
         else if (rd_addr == 3'd6)
            chk(m_fine ? "R3 live sub-second" : "R2 live sub-second", rd_data, 32'(m_sub));
         else if (rd_addr == 3'd0)
            chk("R11 control readback", rd_data,
                {26'd0, m_load, m_step, m_init, m_dec, m_fine, m_en});
      end
   end

   task automatic cycles(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         rd_addr = (rd_addr == 3'd5) ? 3'd6 : 3'd5;
      end
   endtask

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v, a, b;
      #13 rst_n = 1'b1;
      cycles(2);

      // R1 reset state
      rd(3'd0, v); chk("R1 control after reset", v, 32'd0);
      rd(3'd5, v); chk("R1 seconds after reset", v, 32'd0);
      rd(3'd6, v); chk("R1 sub-second after reset", v, 32'd0);
      rd(3'd2, v); chk("R1 addend after reset", v, 32'd0);

      // R10 disabled: command dropped, time holds
      wr(3'd1, 32'd5 << 8);
      wr(3'd0, 32'h08);
      rd(3'd0, v); chk("R10 command dropped while disabled", v, 32'd0);
      cycles(4);
      rd(3'd5, v); chk("R10 seconds hold", v, 32'd0);
      rd(3'd6, v); chk("R10 sub-second hold", v, 32'd0);

      // R5 load, R2 coarse, R4 decimal rollover
      wr(3'd1, 32'd8 << 8);
      rd(3'd1, v); chk("R11 increment field readback", v, 32'd8 << 8);
      wr(3'd3, 32'd5);
      wr(3'd4, 32'd999_999_990);
      wr(3'd0, 32'h0D);
      rd(3'd0, v); chk("R5 load bit pending", v, 32'h0D);
      cycles(1);
      rd(3'd0, v); chk("R5 load bit cleared", v, 32'h05);
      rd(3'd5, v); chk("R5 seconds loaded", v, 32'd5);
      rd(3'd6, v); chk("R5 sub-second loaded", v, 32'd999_999_990);
      cycles(1);
      rd(3'd6, v); chk("R2 coarse step", v, 32'd999_999_998);
      cycles(1);
      rd(3'd6, v); chk("R4 decimal wrap sub-second", v, 32'd6);
      rd(3'd5, v); chk("R4 decimal wrap seconds", v, 32'd6);

      // R6 add step, R7 subtract step (frozen time: increment 0)
      wr(3'd1, 32'd0);
      wr(3'd3, 32'd10);
      wr(3'd4, 32'd999_999_000);
      wr(3'd0, 32'h0D);
      cycles(1);
      wr(3'd3, 32'd2);
      wr(3'd4, 32'd1500);
      wr(3'd0, 32'h15);
      cycles(1);
      rd(3'd5, v); chk("R6 add step seconds with carry", v, 32'd13);
      rd(3'd6, v); chk("R6 add step sub-second", v, 32'd500);
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'h8000_0000 | 32'd999_999_300);
      rd(3'd4, v); chk("R11 preset with sign flag", v, 32'h8000_0000 | 32'd999_999_300);
      wr(3'd0, 32'h15);
      cycles(1);
      rd(3'd5, v); chk("R7 subtract seconds with borrow", v, 32'd11);
      rd(3'd6, v); chk("R7 subtract sub-second", v, 32'd999_999_800);

      // R4 seconds wrap modulo 2^32
      wr(3'd1, 32'd1 << 8);
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'd999_999_999);
      wr(3'd0, 32'h0D);
      cycles(2);
      rd(3'd5, v); chk("R4 seconds wrap", v, 32'd0);
      rd(3'd6, v); chk("R4 sub-second after wrap", v, 32'd0);

      // R4 binary rollover at 2^31
      wr(3'd1, 32'd3 << 8);
      wr(3'd3, 32'd7);
      wr(3'd4, 32'h7FFF_FFFC);
      wr(3'd0, 32'h09);
      cycles(2);
      rd(3'd6, v); chk("R4 binary before wrap", v, 32'h7FFF_FFFF);
      cycles(1);
      rd(3'd6, v); chk("R4 binary wrap sub-second", v, 32'd2);
      rd(3'd5, v); chk("R4 binary wrap seconds", v, 32'd8);

      // R8 addend load, R3 fine rate
      wr(3'd1, 32'd16 << 8);
      wr(3'd2, 32'h8000_0000);
      wr(3'd0, 32'h27);
      rd(3'd0, v); chk("R8 addend bit pending", v, 32'h27);
      cycles(1);
      rd(3'd0, v); chk("R8 addend bit cleared", v, 32'h07);
      wr(3'd3, 32'd0);
      wr(3'd4, 32'd0);
      wr(3'd0, 32'h0F);
      cycles(1);
      rd(3'd6, a);
      cycles(10);
      rd(3'd6, b);
      chk("R3 half addend advance over 10 clocks", b - a, 32'd80);

      // R9 priority: load time beats step and addend
      wr(3'd2, 32'h4000_0000);
      wr(3'd3, 32'd100);
      wr(3'd4, 32'd0);
      wr(3'd0, 32'h3F);
      cycles(1);
      rd(3'd5, v); chk("R9 load time wins seconds", v, 32'd100);
      rd(3'd6, a); chk("R9 load time wins sub-second", a, 32'd0);
      cycles(8);
      rd(3'd6, b);
      chk("R9 addend not loaded under load time", b - a, 32'd64);

      // R9 priority: step beats addend
      wr(3'd3, 32'd1);
      wr(3'd4, 32'd0);
      wr(3'd0, 32'h37);
      cycles(1);
      rd(3'd5, v); chk("R9 step applied", v, 32'd101);
      rd(3'd6, a);
      cycles(8);
      rd(3'd6, b);
      chk("R9 addend not loaded under step", b - a, 32'd64);

      // R8 addend load alone changes rate
      wr(3'd0, 32'h27);
      cycles(1);
      rd(3'd6, a);
      cycles(8);
      rd(3'd6, b);
      chk("R8 quarter addend advance over 8 clocks", b - a, 32'd32);

      cycles(4);
      finish_run();
   end

endmodule